// File: doc/BRIEF.md
# Add/Subtract Status Flag Unit

This block performs byte-wide or word-wide addition and subtraction on two operands and derives six status conditions from each result: carry/borrow, low-byte parity, nibble carry, zero, sign and signed overflow. The result and the status conditions are captured together into registers on any clock edge where an execute strobe is high. Between operations they hold their values.

The status conditions share a 16-bit flag word with three control bits: single-step trap, interrupt enable and string direction. The control bits are never touched by arithmetic. They change only through a dedicated set strobe and a dedicated clear strobe for each bit. The flag word uses a fixed sparse layout in which seven positions are unimplemented and always read as zero. The add-with-carry and subtract-with-borrow selections take their extra term from a carry input, so multi-word arithmetic can be chained by feeding the carry bit back.

Top module: `alu_status_flags`

## Requirements
- R1: On a rising clock edge with `exec_en`=1 the block registers a result that is visible from the next cycle. `op_sel` selects the operation: 00 = A+B, 01 = A+B+carry_in, 10 = A-B, 11 = A-B-carry_in. With `word_sel`=1 the operation uses all 16 bits. With `word_sel`=0 it uses only A[7:0] and B[7:0], and `result_o[15:8]` reads 0.
- R2: Flag bit 0 (carry) is the carry out of the top bit of the selected width (bit 7 or bit 15) for additions, and the borrow out of that bit for subtractions.
- R3: Flag bit 2 (parity) is 1 when `result_o[7:0]` holds an even number of 1 bits, in both widths.
- R4: Flag bit 4 (nibble carry) is the carry out of bit 3 for additions, and the borrow out of bit 3 for subtractions.
- R5: Flag bit 6 (zero) is 1 exactly when the result of the selected width is zero.
- R6: Flag bit 7 (sign) equals bit 7 of the result in byte mode and bit 15 in word mode.
- R7: Flag bit 11 (overflow) is 1 when the true signed result lies outside -128..127 in byte mode or outside -32768..32767 in word mode. For additions this is when the operands share a sign and the result's sign differs. For subtractions it is when the operand signs differ and the result's sign differs from A.
- R8: While `exec_en`=0, the result and the six status flags keep their values.
- R9: The control flags sit at bit 8 (trap), bit 9 (interrupt enable) and bit 10 (direction). Strobe index 0, 1 and 2 of `ctl_set` and `ctl_clr` selects each of them in that order. A set strobe makes its bit 1 from the next cycle, and a clear strobe makes it 0. When both strobes are high, clear wins. With neither strobe, the bit holds its value, including across executed operations.
- R10: Flag bits 1, 3, 5, 12, 13, 14 and 15 always read 0.
- R11: While `rst_n` is low (asynchronous, active low), the result and every flag bit read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Execute strobe: capture result and status flags |
| op_sel | input | 2 | Operation select (see R1) |
| word_sel | input | 1 | 1 = word (16-bit), 0 = byte (8-bit) |
| opnd_a | input | 16 | Operand A (minuend for subtraction) |
| opnd_b | input | 16 | Operand B (subtrahend for subtraction) |
| carry_in | input | 1 | Carry/borrow term for op_sel 01 and 11 |
| ctl_set | input | 3 | Set strobes: [0] trap, [1] interrupt enable, [2] direction |
| ctl_clr | input | 3 | Clear strobes, same indexing as ctl_set |
| result_o | output | 16 | Registered result |
| flags_o | output | 16 | Registered flag word |

## Verification
Random operands cover all four operations in both widths. The bench computes its expected carry and overflow from integer range tests, not from bit formulas, so an error in the choice of sign or carry bit shows up as a mismatch. Directed cases cover the boundaries that separate the flags from each other: 0x7F+1 and 0x8000-1 give overflow without carry, 0xFF+1 in byte mode gives carry and zero with the upper byte cleared, 0-1 gives a borrow, and 0x0F+1 gives a nibble carry alone. Idle cycles and random strobe patterns, including simultaneous set and clear, show that held state is kept and that the control bits stay separate from arithmetic.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int NCTL   = 3;

    // Flag word bit positions (fixed layout)
    localparam int POS_CARRY = 0;
    localparam int POS_PAR   = 2;
    localparam int POS_NIB   = 4;
    localparam int POS_ZERO  = 6;
    localparam int POS_SIGN  = 7;
    localparam int POS_TRAP  = 8;
    localparam int POS_INTEN = 9;
    localparam int POS_DIR   = 10;
    localparam int POS_OVF   = 11;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_ADC = 2'b01,
        OP_SUB = 2'b10,
        OP_SBB = 2'b11
    } arith_op_e;

    typedef struct packed {
        logic ovf;
        logic sign;
        logic zero;
        logic nib;
        logic par;
        logic carry;
    } status_t;

endpackage

// File: rtl/alu_addsub_core.sv
module alu_addsub_core
    import alu_flags_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int BW = BYTE_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  arith_op_e    op_i,
    input  logic         word_i,
    output logic [W-1:0] a_sz_o,
    output logic [W-1:0] b_sz_o,
    output logic [W-1:0] res_o,
    output logic         cout_o
);

    localparam int UPPER = W - BW;

    logic [W:0] raw;
    logic       ci;
    logic       is_sub;

    always_comb begin
        is_sub = (op_i == OP_SUB) || (op_i == OP_SBB);
        ci     = ((op_i == OP_ADC) || (op_i == OP_SBB)) ? cin_i : 1'b0;
        a_sz_o = word_i ? a_i : {{UPPER{1'b0}}, a_i[BW-1:0]};
        b_sz_o = word_i ? b_i : {{UPPER{1'b0}}, b_i[BW-1:0]};
        if (is_sub)
            raw = {1'b0, a_sz_o} - {1'b0, b_sz_o} - {{W{1'b0}}, ci};
        else
            raw = {1'b0, a_sz_o} + {1'b0, b_sz_o} + {{W{1'b0}}, ci};
        if (word_i) begin
            res_o  = raw[W-1:0];
            cout_o = raw[W];
        end else begin
            res_o  = {{UPPER{1'b0}}, raw[BW-1:0]};
            cout_o = raw[BW];
        end
    end

endmodule

// File: rtl/alu_flag_eval.sv
module alu_flag_eval
    import alu_flags_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int BW = BYTE_W,
    parameter int NW = NIB_W
) (
    input  logic [W-1:0] a_sz_i,
    input  logic [W-1:0] b_sz_i,
    input  logic [W-1:0] res_i,
    input  logic         cout_i,
    input  arith_op_e    op_i,
    input  logic         word_i,
    output status_t      st_o
);

    logic sa, sb, sr, is_sub;

    always_comb begin
        is_sub = (op_i == OP_SUB) || (op_i == OP_SBB);
        sa = word_i ? a_sz_i[W-1] : a_sz_i[BW-1];
        sb = word_i ? b_sz_i[W-1] : b_sz_i[BW-1];
        sr = word_i ? res_i[W-1]  : res_i[BW-1];
        st_o.carry = cout_i;
        st_o.par   = ~^res_i[BW-1:0];
        // carry/borrow into bit NW recovered from the operand and result bits there
        st_o.nib   = a_sz_i[NW] ^ b_sz_i[NW] ^ res_i[NW];
        st_o.zero  = (res_i == '0);
        st_o.sign  = sr;
        if (is_sub)
            st_o.ovf = (sa != sb) && (sr != sa);
        else
            st_o.ovf = (sa == sb) && (sr != sa);
    end

endmodule

// File: rtl/alu_ctrl_flags.sv
module alu_ctrl_flags
    import alu_flags_pkg::*;
#(
    parameter int N = NCTL
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q_o[i] <= 1'b0;
            else if (clr_i[i])
                q_o[i] <= 1'b0;
            else if (set_i[i])
                q_o[i] <= 1'b1;
        end
    end

endmodule

// File: rtl/alu_status_flags.sv
module alu_status_flags
    import alu_flags_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        exec_en,
    input  logic [1:0]  op_sel,
    input  logic        word_sel,
    input  logic [15:0] opnd_a,
    input  logic [15:0] opnd_b,
    input  logic        carry_in,
    input  logic [2:0]  ctl_set,
    input  logic [2:0]  ctl_clr,
    output logic [15:0] result_o,
    output logic [15:0] flags_o
);

    arith_op_e         op;
    logic [WORD_W-1:0] a_sz, b_sz, res_d;
    logic              cout;
    status_t           st_d, st_q;
    logic [NCTL-1:0]   ctl_q;

    assign op = arith_op_e'(op_sel);

    alu_addsub_core u_core (
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .cin_i  (carry_in),
        .op_i   (op),
        .word_i (word_sel),
        .a_sz_o (a_sz),
        .b_sz_o (b_sz),
        .res_o  (res_d),
        .cout_o (cout)
    );

    alu_flag_eval u_eval (
        .a_sz_i (a_sz),
        .b_sz_i (b_sz),
        .res_i  (res_d),
        .cout_i (cout),
        .op_i   (op),
        .word_i (word_sel),
        .st_o   (st_d)
    );

    alu_ctrl_flags u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ctl_set),
        .clr_i (ctl_clr),
        .q_o   (ctl_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
            st_q     <= '0;
        end else if (exec_en) begin
            result_o <= res_d;
            st_q     <= st_d;
        end
    end

    always_comb begin
        flags_o            = '0;
        flags_o[POS_CARRY] = st_q.carry;
        flags_o[POS_PAR]   = st_q.par;
        flags_o[POS_NIB]   = st_q.nib;
        flags_o[POS_ZERO]  = st_q.zero;
        flags_o[POS_SIGN]  = st_q.sign;
        flags_o[POS_OVF]   = st_q.ovf;
        flags_o[POS_TRAP]  = ctl_q[0];
        flags_o[POS_INTEN] = ctl_q[1];
        flags_o[POS_DIR]   = ctl_q[2];
    end

endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        exec_en,
    input logic        word_sel,
    input logic [2:0]  ctl_set,
    input logic [2:0]  ctl_clr,
    input logic [15:0] result_o,
    input logic [15:0] flags_o
);

    // R10
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & 16'hF02A) == 16'h0000);

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en |=> flags_o[6] == (result_o == 16'h0000));

    // R3
    parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en |=> flags_o[2] == ~^result_o[7:0]);

    // R6
    sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en |=> flags_o[7] == ($past(word_sel) ? result_o[15] : result_o[7]));

    // R1
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && !word_sel) |=> result_o[15:8] == 8'h00);

    // R8
    hold_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> $stable(result_o) && $stable(flags_o[7:0]) && $stable(flags_o[11]));

    // R9
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_set == 3'b000 && ctl_clr == 3'b000) |=> $stable(flags_o[10:8]));

    // R9
    ctl_clr_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_clr != 3'b000) |=> (flags_o[10:8] & $past(ctl_clr)) == 3'b000);

    // R9
    ctl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_set & ~ctl_clr) != 3'b000) |=>
            (flags_o[10:8] & $past(ctl_set & ~ctl_clr)) == $past(ctl_set & ~ctl_clr));

endmodule

bind alu_status_flags alu_flags_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec_en  (exec_en),
    .word_sel (word_sel),
    .ctl_set  (ctl_set),
    .ctl_clr  (ctl_clr),
    .result_o (result_o),
    .flags_o  (flags_o)
);

// File: tb/alu_status_flags_tb.sv
module alu_status_flags_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exec_en;
    logic [1:0]  op_sel;
    logic        word_sel;
    logic [15:0] opnd_a, opnd_b;
    logic        carry_in;
    logic [2:0]  ctl_set, ctl_clr;
    logic [15:0] result_o, flags_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] exp_res;
    logic [5:0]  exp_st;   // {ovf, sign, zero, nib, par, carry}
    logic [2:0]  exp_ctl;

    always #10 clk = ~clk;   // 50 MHz

    alu_status_flags u_dut (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_sel(op_sel),
        .word_sel(word_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .carry_in(carry_in), .ctl_set(ctl_set), .ctl_clr(ctl_clr),
        .result_o(result_o), .flags_o(flags_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected result and status from integer arithmetic and range tests
    task automatic model(input logic [15:0] a, input logic [15:0] b, input logic ci_in,
                         input logic [1:0] op, input logic word);
        int ua, ub, sa, sb, ci, u, s, n, lim;
        logic [15:0] r;
        logic cf, of, af;
        ci  = op[0] ? int'(ci_in) : 0;
        lim = word ? 65536 : 256;
        ua  = word ? int'(a) : int'(a[7:0]);
        ub  = word ? int'(b) : int'(b[7:0]);
        sa  = word ? int'($signed(a)) : int'($signed(a[7:0]));
        sb  = word ? int'($signed(b)) : int'($signed(b[7:0]));
        if (op[1]) begin
            u = ua - ub - ci; s = sa - sb - ci;
            n = (ua % 16) - (ub % 16) - ci; cf = (u < 0); af = (n < 0);
        end else begin
            u = ua + ub + ci; s = sa + sb + ci;
            n = (ua % 16) + (ub % 16) + ci; cf = (u >= lim); af = (n > 15);
        end
        if (u < 0) u = u + lim;
        u = u % lim;
        r = 16'(u);
        of = word ? (s > 32767 || s < -32768) : (s > 127 || s < -128);
        exp_res = r;
        exp_st  = {of, (word ? r[15] : r[7]), (r == 16'h0), af, ~^r[7:0], cf};
    endtask

    task automatic check_all();
        chk("R1 result", result_o, exp_res);
        chk("R2 carry", {15'h0, flags_o[0]}, {15'h0, exp_st[0]});
        chk("R3 parity", {15'h0, flags_o[2]}, {15'h0, exp_st[1]});
        chk("R4 nibble", {15'h0, flags_o[4]}, {15'h0, exp_st[2]});
        chk("R5 zero", {15'h0, flags_o[6]}, {15'h0, exp_st[3]});
        chk("R6 sign", {15'h0, flags_o[7]}, {15'h0, exp_st[4]});
        chk("R7 overflow", {15'h0, flags_o[11]}, {15'h0, exp_st[5]});
        chk("R9 control", {13'h0, flags_o[10:8]}, {13'h0, exp_ctl});
        chk("R10 unused", flags_o & 16'hF02A, 16'h0000);
    endtask

    // Drive at negedge, clock it in, check at next negedge
    task automatic step(input logic en, input logic [1:0] op, input logic word,
                        input logic [15:0] a, input logic [15:0] b, input logic ci,
                        input logic [2:0] s, input logic [2:0] c);
        exec_en = en; op_sel = op; word_sel = word; opnd_a = a; opnd_b = b;
        carry_in = ci; ctl_set = s; ctl_clr = c;
        if (en) model(a, b, ci, op, word);   // R8: otherwise expectation held
        exp_ctl = (exp_ctl | s) & ~c;        // R9: clear wins
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));
        rst_n = 1'b0; exec_en = 0; op_sel = 0; word_sel = 0; opnd_a = 0; opnd_b = 0;
        carry_in = 0; ctl_set = 0; ctl_clr = 0;
        exp_res = 0; exp_st = 0; exp_ctl = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk("R11 reset result", result_o, 16'h0);
        chk("R11 reset flags", flags_o, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners
        step(1, 2'b00, 0, 16'h007F, 16'h0001, 0, 0, 0); // R7 byte overflow, R4 nibble
        step(1, 2'b00, 0, 16'hAAFF, 16'h5501, 0, 0, 0); // R2/R5 byte carry and zero, R1 upper cleared
        step(1, 2'b10, 1, 16'h8000, 16'h0001, 0, 0, 0); // R7 word overflow on subtract
        step(1, 2'b10, 1, 16'h0000, 16'h0001, 0, 0, 0); // R2 borrow
        step(1, 2'b00, 1, 16'h000F, 16'h0001, 0, 0, 0); // R4 nibble carry only
        step(1, 2'b01, 1, 16'hFFFF, 16'h0000, 1, 0, 0); // R1 carry term in word add
        step(1, 2'b11, 0, 16'h0010, 16'h000F, 1, 0, 0); // R1 borrow term, zero result
        step(0, 2'b00, 1, 16'h1234, 16'h4321, 0, 0, 0); // R8 idle holds
        step(0, 2'b00, 1, 16'h0000, 16'h0000, 0, 3'b111, 0); // R9 set all
        step(1, 2'b10, 1, 16'h0005, 16'h0005, 0, 0, 0); // R9 arithmetic leaves control
        step(0, 2'b00, 1, 16'h0000, 16'h0000, 0, 3'b011, 3'b110); // R9 clear wins
        step(0, 2'b00, 1, 16'h0000, 16'h0000, 0, 0, 3'b001);

        // Constrained random
        for (int i = 0; i < 1500; i++) begin
            logic [2:0] s, c;
            s = ($urandom % 4 == 0) ? 3'($urandom) : 3'b000;
            c = ($urandom % 4 == 0) ? 3'($urandom) : 3'b000;
            step(($urandom % 4) != 0, 2'($urandom), 1'($urandom), 16'($urandom),
                 16'($urandom), 1'($urandom), s, c);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule